// File: doc/BRIEF.md
# Split Transaction Outstanding Tracker

This block sits beside a bus requester that works in the split-capable bus mode. When the requester wants to issue a read or write whose answer will come back later, it offers the command and the expected byte count on the request port. If the command is allowed to be split, the tracker hands out a free tag and records the command and the byte count against that tag. The completer later returns the data in one or more completions. Each completion carries the tag, the number of bytes it delivers and a flag that marks the final piece. The tracker subtracts each completion from the entry's remaining count. It retires the entry when nothing is left, so the tag can be handed out again.

The table has a fixed number of entries. The lowest free entry is always chosen, and the request port stops accepting while every entry is busy. Commands that may not be split are refused without taking a tag. Interrupt Acknowledge is among them and is refused in every mode. In the conventional bus mode, requests are finished by the delayed-transaction mechanism outside this block, so no entry is ever taken. A malformed completion sets a sticky error flag and leaves the table untouched.

Top module: `split_tracker`

## Requirements
- R1: After synchronous reset, no entry is busy. `full` and `error` are 0, and `req_ready` is 1.
- R2: In split mode (`split_mode`=1), a handshake (`req_valid`&`req_ready`) carrying an eligible command and a nonzero byte count raises `req_accept` in the same cycle, and the entry becomes busy at the next edge. The eligible command codes are 0x2 I/O read, 0x3 I/O write, 0x6 dword memory read, 0x8 block-read alias, 0xA config read, 0xB config write and 0xE block memory read.
- R3: A handshake carrying any other code, including Interrupt Acknowledge (0x0), raises `req_reject` and allocates no tag. This holds in both modes.
- R4: `req_tag` reports the lowest-numbered entry that is free at the start of the cycle. No two busy entries ever share a tag.
- R5: `full` is 1 exactly when all 16 entries are busy. In split mode, `req_ready` is then 0 and no request is taken.
- R6: In conventional mode (`split_mode`=0), `req_ready` stays 1, `req_accept` stays 0 and no entry is allocated.
- R7: A completion to a busy tag subtracts `cpl_bytes` from that entry's remaining count. When the count reaches zero, `cpl_retire` pulses in the same cycle, `cpl_cmd` shows the recorded command and the entry becomes free. Completions to different tags may interleave in any order.
- R8: A completion whose `cpl_last` disagrees with whether it empties the entry is dropped and sets `error`.
- R9: A completion to a free tag, or one with a zero byte count, or one larger than the remaining count, is dropped and sets `error` from the next cycle. `error` stays set until reset.
- R10: A tag retired in cycle t can be granted again in cycle t+1. A request in cycle t is given a different free tag.
- R11: A request with a zero byte count raises `req_reject` and allocates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_mode | input | 1 | 1 = split-capable bus mode, 0 = conventional mode |
| req_valid | input | 1 | Request offered |
| req_cmd | input | 4 | Bus command code |
| req_bytes | input | 12 | Expected byte count |
| req_ready | output | 1 | Request can be taken this cycle |
| req_accept | output | 1 | Request taken and tag granted |
| req_reject | output | 1 | Request refused, no tag |
| req_tag | output | 4 | Granted tag (lowest free entry) |
| cpl_valid | input | 1 | Completion present |
| cpl_tag | input | 4 | Tag of the completion |
| cpl_bytes | input | 12 | Bytes delivered by this completion |
| cpl_last | input | 1 | Completer marks this as the final piece |
| cpl_retire | output | 1 | Completion emptied its entry |
| cpl_cmd | output | 4 | Recorded command of the addressed entry |
| full | output | 1 | All entries busy |
| error | output | 1 | Sticky completion error |

## Verification
Requests are issued back to back until the table is full. This shows whether the lowest free entry is chosen and whether the port holds off at the limit. Two entries are then emptied in interleaved partial pieces, which tells true per-tag byte accounting apart from a one-shot free. A retire and a request in the same cycle show whether a tag is freed too early or too late. Refused codes, zero counts, wrong last flags, oversize pieces and stray tags are each followed by a legal operation, which shows whether the table stayed untouched. A long seeded random run mixes all of these with mode changes.

// File: rtl/split_pkg.sv
package split_pkg;

    localparam logic [3:0] CMD_INTACK    = 4'h0;
    localparam logic [3:0] CMD_IO_RD     = 4'h2;
    localparam logic [3:0] CMD_IO_WR     = 4'h3;
    localparam logic [3:0] CMD_MEM_RD_DW = 4'h6;
    localparam logic [3:0] CMD_MRB_ALIAS = 4'h8;
    localparam logic [3:0] CMD_CFG_RD    = 4'hA;
    localparam logic [3:0] CMD_CFG_WR    = 4'hB;
    localparam logic [3:0] CMD_MEM_RD_BK = 4'hE;

    typedef enum logic [1:0] {
        CPL_IDLE = 2'd0,
        CPL_PART = 2'd1,
        CPL_DONE = 2'd2,
        CPL_BAD  = 2'd3
    } cpl_verdict_e;

    function automatic logic split_eligible(input logic [3:0] cmd);
        case (cmd)
            CMD_IO_RD, CMD_IO_WR, CMD_MEM_RD_DW, CMD_MRB_ALIAS,
            CMD_CFG_RD, CMD_CFG_WR, CMD_MEM_RD_BK: return 1'b1;
            default:                               return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/split_cmd_filter.sv
module split_cmd_filter
    import split_pkg::*;
(
    input  logic [3:0] cmd,
    output logic       eligible
);
    always_comb eligible = split_eligible(cmd);
endmodule

// File: rtl/split_tag_alloc.sv
module split_tag_alloc #(
    parameter int unsigned N_TAGS = 16,
    parameter int unsigned TAG_W  = 4
) (
    input  logic [N_TAGS-1:0] busy,
    output logic [TAG_W-1:0]  free_tag,
    output logic              any_free
);
    // Scan downward so the lowest free index is the one that remains.
    always_comb begin
        free_tag = '0;
        any_free = 1'b0;
        for (int i = N_TAGS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                free_tag = TAG_W'(i);
                any_free = 1'b1;
            end
        end
    end
endmodule

// File: rtl/split_entry_table.sv
module split_entry_table
    import split_pkg::*;
#(
    parameter int unsigned N_TAGS = 16,
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned BCNT_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc_en,
    input  logic [TAG_W-1:0]   alloc_tag,
    input  logic [3:0]         alloc_cmd,
    input  logic [BCNT_W-1:0]  alloc_bytes,
    input  logic               cpl_valid,
    input  logic [TAG_W-1:0]   cpl_tag,
    input  logic [BCNT_W-1:0]  cpl_bytes,
    input  logic               cpl_last,
    output logic [N_TAGS-1:0]  busy,
    output cpl_verdict_e       verdict,
    output logic [3:0]         hit_cmd
);
    logic [BCNT_W-1:0] rem_arr [N_TAGS];
    logic [3:0]        cmd_arr [N_TAGS];

    logic              hit_busy;
    logic [BCNT_W-1:0] hit_rem;
    logic              empties;

    always_comb begin
        hit_busy = 1'b0;
        hit_rem  = '0;
        hit_cmd  = '0;
        for (int i = 0; i < N_TAGS; i++) begin
            if (cpl_tag == TAG_W'(i)) begin
                hit_busy = busy[i];
                hit_rem  = rem_arr[i];
                hit_cmd  = cmd_arr[i];
            end
        end
    end

    always_comb begin
        empties = (cpl_bytes == hit_rem);
        if (!cpl_valid) begin
            verdict = CPL_IDLE;
        end else if (!hit_busy || cpl_bytes == '0 || cpl_bytes > hit_rem) begin
            verdict = CPL_BAD;
        end else if (cpl_last != empties) begin
            verdict = CPL_BAD;
        end else if (empties) begin
            verdict = CPL_DONE;
        end else begin
            verdict = CPL_PART;
        end
    end

    for (genvar g = 0; g < N_TAGS; g++) begin : g_entry
        logic              busy_q;
        logic [BCNT_W-1:0] rem_q;
        logic [3:0]        cmd_q;
        logic              sel_alloc;
        logic              sel_cpl;

        assign sel_alloc = alloc_en && (alloc_tag == TAG_W'(g));
        assign sel_cpl   = (cpl_tag == TAG_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                busy_q <= 1'b0;
                rem_q  <= '0;
                cmd_q  <= '0;
            end else if (sel_alloc) begin
                busy_q <= 1'b1;
                rem_q  <= alloc_bytes;
                cmd_q  <= alloc_cmd;
            end else if (sel_cpl && verdict == CPL_PART) begin
                rem_q  <= rem_q - cpl_bytes;
            end else if (sel_cpl && verdict == CPL_DONE) begin
                busy_q <= 1'b0;
                rem_q  <= '0;
            end
        end

        assign busy[g]    = busy_q;
        assign rem_arr[g] = rem_q;
        assign cmd_arr[g] = cmd_q;
    end
endmodule

// File: rtl/split_tracker.sv
module split_tracker
    import split_pkg::*;
#(
    parameter int unsigned N_TAGS = 16,
    parameter int unsigned BCNT_W = 12,
    parameter int unsigned TAG_W  = $clog2(N_TAGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              split_mode,
    input  logic              req_valid,
    input  logic [3:0]        req_cmd,
    input  logic [BCNT_W-1:0] req_bytes,
    output logic              req_ready,
    output logic              req_accept,
    output logic              req_reject,
    output logic [TAG_W-1:0]  req_tag,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [BCNT_W-1:0] cpl_bytes,
    input  logic              cpl_last,
    output logic              cpl_retire,
    output logic [3:0]        cpl_cmd,
    output logic              full,
    output logic              error
);
    logic              eligible;
    logic [N_TAGS-1:0] busy;
    logic [TAG_W-1:0]  free_tag;
    logic              any_free;
    cpl_verdict_e      verdict;
    logic              err_q;
    logic              handshake;
    logic              zero_len;

    split_cmd_filter u_filter (
        .cmd      (req_cmd),
        .eligible (eligible)
    );

    split_tag_alloc #(
        .N_TAGS (N_TAGS),
        .TAG_W  (TAG_W)
    ) u_alloc (
        .busy     (busy),
        .free_tag (free_tag),
        .any_free (any_free)
    );

    split_entry_table #(
        .N_TAGS (N_TAGS),
        .TAG_W  (TAG_W),
        .BCNT_W (BCNT_W)
    ) u_table (
        .clk         (clk),
        .rst         (rst),
        .alloc_en    (req_accept),
        .alloc_tag   (free_tag),
        .alloc_cmd   (req_cmd),
        .alloc_bytes (req_bytes),
        .cpl_valid   (cpl_valid),
        .cpl_tag     (cpl_tag),
        .cpl_bytes   (cpl_bytes),
        .cpl_last    (cpl_last),
        .busy        (busy),
        .verdict     (verdict),
        .hit_cmd     (cpl_cmd)
    );

    always_comb begin
        full       = !any_free;
        req_ready  = !split_mode || any_free;
        zero_len   = (req_bytes == '0);
        handshake  = req_valid && req_ready;
        req_reject = handshake && (!eligible || zero_len);
        req_accept = handshake && split_mode && eligible && !zero_len;
        req_tag    = free_tag;
        cpl_retire = (verdict == CPL_DONE);
        error      = err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (verdict == CPL_BAD) begin
            err_q <= 1'b1;
        end
    end
endmodule

// File: rtl/split_tracker_chk.sv
module split_tracker_chk
    import split_pkg::*;
#(
    parameter int unsigned N_TAGS = 16,
    parameter int unsigned BCNT_W = 12,
    parameter int unsigned TAG_W  = $clog2(N_TAGS)
) (
    input logic              clk,
    input logic              rst,
    input logic              split_mode,
    input logic              req_valid,
    input logic [3:0]        req_cmd,
    input logic [BCNT_W-1:0] req_bytes,
    input logic              req_ready,
    input logic              req_accept,
    input logic              req_reject,
    input logic [TAG_W-1:0]  req_tag,
    input logic              cpl_valid,
    input logic [TAG_W-1:0]  cpl_tag,
    input logic [BCNT_W-1:0] cpl_bytes,
    input logic              cpl_last,
    input logic              cpl_retire,
    input logic [3:0]        cpl_cmd,
    input logic              full,
    input logic              error
);
    a_r5_hold_off_when_full: assert property (@(posedge clk) disable iff (rst)
        (split_mode && full) |-> !req_ready);

    a_r3_intack_never_granted: assert property (@(posedge clk) disable iff (rst)
        req_accept |-> (req_cmd != CMD_INTACK));

    a_r11_zero_never_granted: assert property (@(posedge clk) disable iff (rst)
        req_accept |-> (req_bytes != '0));

    a_r6_conv_mode_no_grant: assert property (@(posedge clk) disable iff (rst)
        !split_mode |-> !req_accept);

    a_r2_grant_needs_valid: assert property (@(posedge clk) disable iff (rst)
        req_accept |-> (req_valid && !req_reject));

    a_r10_no_back_to_back_same_tag: assert property (@(posedge clk) disable iff (rst)
        req_accept |=> !(req_accept && req_tag == $past(req_tag)));

    a_r8_retire_carries_last: assert property (@(posedge clk) disable iff (rst)
        cpl_retire |-> (cpl_valid && cpl_last && cpl_bytes != '0));

    a_r9_error_sticky: assert property (@(posedge clk) disable iff (rst)
        error |=> error);

    a_r9_error_from_completion: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> $past(cpl_valid && !cpl_retire));
endmodule

bind split_tracker split_tracker_chk #(
    .N_TAGS (N_TAGS),
    .BCNT_W (BCNT_W),
    .TAG_W  (TAG_W)
) u_chk (.*);

// File: tb/test_split_tracker.sv
module test_split_tracker;
    localparam int N  = 16;
    localparam int BW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          split_mode = 1'b1;
    logic          req_valid = 1'b0;
    logic [3:0]    req_cmd = '0;
    logic [BW-1:0] req_bytes = '0;
    logic          req_ready, req_accept, req_reject;
    logic [3:0]    req_tag;
    logic          cpl_valid = 1'b0;
    logic [3:0]    cpl_tag = '0;
    logic [BW-1:0] cpl_bytes = '0;
    logic          cpl_last = 1'b0;
    logic          cpl_retire;
    logic [3:0]    cpl_cmd;
    logic          full, error;

    split_tracker i_split_tracker (
        .clk(clk), .rst(rst), .split_mode(split_mode),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_bytes(req_bytes),
        .req_ready(req_ready), .req_accept(req_accept), .req_reject(req_reject),
        .req_tag(req_tag), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
        .cpl_bytes(cpl_bytes), .cpl_last(cpl_last), .cpl_retire(cpl_retire),
        .cpl_cmd(cpl_cmd), .full(full), .error(error)
    );

    always #10 clk = ~clk;

    int n_run  = 0;
    int n_fail = 0;

    bit       m_busy [N];
    int       m_rem  [N];
    int       m_cmd  [N];
    bit       m_err;
    bit       mode_v = 1'b1;

    int       elig_codes [7] = '{2, 3, 6, 8, 10, 11, 14};

    task automatic chk(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit m_elig(int c);
        foreach (elig_codes[i]) if (elig_codes[i] == c) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit m_full();
        foreach (m_busy[i]) if (!m_busy[i]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int m_low_free();
        for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
        return 0;
    endfunction

    task automatic clear_model();
        foreach (m_busy[i]) begin
            m_busy[i] = 1'b0;
            m_rem[i]  = 0;
            m_cmd[i]  = 0;
        end
        m_err = 1'b0;
    endtask

    // One bus cycle: drive at the falling edge, check the outputs, then let the edge update the model.
    task automatic step(string req, bit rv, int cmd, int bytes,
                        bit cv, int ctag, int cbytes, bit clast);
        bit ready_e, fire, acc_e, rej_e, elig, ok_e, fin, bad_e;
        int tag_e;
        @(negedge clk);
        split_mode = mode_v;
        req_valid  = rv;
        req_cmd    = 4'(cmd);
        req_bytes  = BW'(bytes);
        cpl_valid  = cv;
        cpl_tag    = 4'(ctag);
        cpl_bytes  = BW'(cbytes);
        cpl_last   = clast;
        #1;
        elig    = m_elig(cmd);
        ready_e = !mode_v || !m_full();
        fire    = rv && ready_e;
        acc_e   = fire && mode_v && elig && (bytes != 0);
        rej_e   = fire && (!elig || bytes == 0);
        tag_e   = m_low_free();
        ok_e    = 1'b0;
        fin     = 1'b0;
        if (cv && m_busy[ctag] && cbytes > 0 && cbytes <= m_rem[ctag]) begin
            fin  = (cbytes == m_rem[ctag]);
            ok_e = (clast == fin);
        end
        bad_e = cv && !ok_e;
        chk(req, "req_ready", int'(req_ready), int'(ready_e));
        chk(req, "req_accept", int'(req_accept), int'(acc_e));
        chk(req, "req_reject", int'(req_reject), int'(rej_e));
        if (acc_e) chk(req, "req_tag", int'(req_tag), tag_e);
        chk(req, "full", int'(full), int'(m_full()));
        chk(req, "error", int'(error), int'(m_err));
        chk(req, "cpl_retire", int'(cpl_retire), int'(ok_e && fin));
        if (ok_e && fin) chk(req, "cpl_cmd", int'(cpl_cmd), m_cmd[ctag]);
        @(posedge clk);
        if (acc_e) begin
            if (m_busy[tag_e]) begin
                n_fail++;
                $display("FAIL R4 duplicate tag actual=%0d expected=free", tag_e);
            end
            m_busy[tag_e] = 1'b1;
            m_rem[tag_e]  = bytes;
            m_cmd[tag_e]  = cmd;
        end
        if (ok_e) begin
            if (fin) m_busy[ctag] = 1'b0;
            else     m_rem[ctag] -= cbytes;
        end
        if (bad_e) m_err = 1'b1;
    endtask

    task automatic idle(string req);
        step(req, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        cpl_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        clear_model();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int t, p, len;
        bit cv, rv, cl;
        int cmd, by, ct, cb;
        void'($urandom(32'd1234));
        clear_model();

        // R1: reset state
        do_reset();
        #1;
        chk("R1", "full", int'(full), 0);
        chk("R1", "error", int'(error), 0);
        chk("R1", "req_ready", int'(req_ready), 1);
        idle("R1");

        // R4 / R5: fill in order, then hold off
        for (int i = 0; i < N; i++)
            step("R4", 1, elig_codes[i % 7], i * 8 + 4, 0, 0, 0, 0);
        step("R5", 1, 14, 16, 0, 0, 0, 0);
        chk("R5", "full after fill", int'(full), 1);

        // R7: interleaved multipart completions on tags 9 and 5
        step("R7", 0, 0, 0, 1, 9, 30, 0);
        step("R7", 0, 0, 0, 1, 5, 20, 0);
        step("R7", 0, 0, 0, 1, 9, 46, 1);
        step("R7", 0, 0, 0, 1, 5, 24, 1);

        // R10: retire tag 3 while requesting; then tag 3 is next
        step("R10", 1, 6, 40, 1, 3, 28, 1);
        step("R10", 1, 2, 12, 0, 0, 0, 0);
        chk("R10", "freed tag regranted", int'(m_busy[3]), 1);

        // R3 / R11: refused requests leave tag 9 free
        step("R3", 1, 0, 8, 0, 0, 0, 0);
        step("R3", 1, 7, 8, 0, 0, 0, 0);
        step("R11", 1, 10, 0, 0, 0, 0, 0);
        step("R3", 1, 11, 8, 0, 0, 0, 0);

        // R8: wrong last flag is dropped, entry unchanged
        step("R8", 0, 0, 0, 1, 0, 4, 0);
        idle("R8");
        step("R8", 0, 0, 0, 1, 0, 4, 1);

        // R9: stray tag, oversize, zero length
        do_reset();
        step("R9", 0, 0, 0, 1, 2, 4, 1);
        idle("R9");
        do_reset();
        step("R9", 1, 3, 10, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 1, 0, 11, 1);
        step("R9", 0, 0, 0, 1, 0, 0, 0);
        step("R9", 0, 0, 0, 1, 0, 10, 1);
        idle("R9");

        // R6: conventional mode allocates nothing
        do_reset();
        mode_v = 1'b0;
        step("R6", 1, 14, 32, 0, 0, 0, 0);
        step("R6", 1, 0, 32, 0, 0, 0, 0);
        mode_v = 1'b1;
        step("R6", 1, 8, 32, 0, 0, 0, 0);
        chk("R6", "first split tag is 0", int'(m_busy[0]), 1);

        // Seeded random traffic
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            mode_v = ($urandom_range(0, 19) != 0);
            rv  = $urandom_range(0, 1);
            cmd = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 15))
                                              : elig_codes[$urandom_range(0, 6)];
            by  = ($urandom_range(0, 19) == 0) ? 0 : int'($urandom_range(1, 64));
            cv = 1'b0; ct = 0; cb = 0; cl = 1'b0;
            if ($urandom_range(0, 9) < 6) begin
                p = $urandom_range(0, N - 1);
                for (int j = 0; j < N; j++) begin
                    t = (p + j) % N;
                    if (m_busy[t] && !cv) begin
                        cv = 1'b1; ct = t;
                        len = m_rem[t];
                        cb = ($urandom_range(0, 1) == 0) ? len : int'($urandom_range(1, len));
                        cl = (cb == len);
                    end
                end
                if (cv && $urandom_range(0, 49) == 0) cl = !cl;
            end
            step("R7", rv, cmd, by, cv, ct, cb, cl);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule